// File: doc/BRIEF.md
# Power-Domain Scan Segment Controller

This block steers scan shifting across two scan segments that each sit wholly inside one power domain. Domain A is always powered; domain B can be switched off. No scan path crosses the domain boundary on its own: the controller decides, from the power state of domain B and the selected test mode, whether segment B joins the shift path behind segment A or is skipped. When it is skipped, only segment A receives a scan enable and its serial output goes straight to the scan-out pin.

Domain B must be requested on and report power-good before it may shift. The power-good input is synchronized and must then stay high for a settle count given on an input port before segment B is enabled. Isolation on the outputs of domain B is held while the domain is down, rises in the same cycle the power request falls, and is released only one cycle after segment B has been enabled. The clamp value is selectable. During shift every clock-gate enable is forced open so no flop drops out of the chain.

Domain B is tested in its own mode with the domain powered up (full mode); domain A alone is tested in bypass mode.

Top module: `pds_seg_ctrl`

## Requirements
- R1: `se_a` equals `scan_en` at all times; `se_b` is 1 only when `scan_en` is 1, `full_mode` is 1 and segment B is enabled.
- R2: Power-good passes through two synchronizing flops. With `b_pwr_req` held at 1 and `b_pwr_good` rising before rising edge 0 and held, segment B becomes enabled after rising edge `settle_cycles`+3 and not earlier.
- R3: When `b_pwr_req` is 0, segment B is disabled and `iso_en` is 1 in that same cycle; when `b_pwr_good` falls before edge 0, segment B is disabled after edge 2.
- R4: `iso_en` falls only after segment B has been enabled: with the R2 timing it is 1 up to edge `settle_cycles`+3 and 0 after edge `settle_cycles`+4.
- R5: While `iso_en` is 1 every bit of `b_iso_out` equals `clamp_val` (0 or 1); while it is 0 `b_iso_out` equals `b_func_out`.
- R6: While `scan_en` is 1 every bit of `cg_en` is 1; while it is 0 `cg_en` equals `func_cg_en`.
- R7: Full path (when `full_mode`=1 and segment B enabled): `bypass_sel`=0, `seg_b_si`=`seg_a_so`, `scan_out`=`seg_b_so`. Otherwise `bypass_sel`=1, `seg_b_si`=0, `scan_out`=`seg_a_so`.
- R8: During and directly after reset, segment B is disabled, `iso_en`=1 and `bypass_sel`=1.
- R9: With `settle_cycles`=0 segment B becomes enabled after edge 3.
- R10: A drop of the synchronized power-good during the settle count restarts the count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| b_pwr_req | input | 1 | Domain B is requested to be on |
| b_pwr_good | input | 1 | Asynchronous power-good from domain B |
| scan_en | input | 1 | Global scan enable |
| full_mode | input | 1 | 1: include segment B, 0: domain A only |
| settle_cycles | input | CNT_W | Extra stable cycles required after sync |
| clamp_val | input | 1 | Isolation clamp level |
| func_cg_en | input | NCG | Functional clock-gate enables |
| b_func_out | input | NISO | Domain B outputs into domain A |
| seg_a_so | input | 1 | Serial output of segment A |
| seg_b_so | input | 1 | Serial output of segment B |
| se_a | output | 1 | Scan enable of segment A |
| se_b | output | 1 | Scan enable of segment B |
| cg_en | output | NCG | Clock-gate enables after override |
| iso_en | output | 1 | Isolation enable for domain B |
| b_iso_out | output | NISO | Clamped domain B outputs |
| bypass_sel | output | 1 | 1 when segment B is skipped |
| seg_b_si | output | 1 | Serial input of segment B |
| scan_out | output | 1 | Scan-out pin |

## Verification
The bench aims at the exact edge where segment B comes alive for settle counts of zero and above: an off-by-one counter would enable shifting a cycle early into a domain that is not yet stable, or late and lose shift bits. It drops power-good in the middle of the settle count, which a design that only resumes counting would answer by enabling segment B too soon. It also removes the power request while segment B shifts, where a design that registered isolation would leave outputs unclamped for a cycle, and it checks that isolation never releases before the segment is enabled.

// File: rtl/pds_pkg.sv
package pds_pkg;

    // Power sequence of the switchable domain
    typedef enum logic [1:0] {
        B_OFF    = 2'd0,
        B_WAKE   = 2'd1,
        B_ON_ISO = 2'd2,
        B_ON     = 2'd3
    } bdom_state_e;

    // Scan path routing decision
    typedef struct packed {
        logic full;     // segment B joins behind segment A
        logic bypass;   // segment B skipped
    } route_t;

    function automatic route_t pick_route(input logic full_mode, input logic seg_ok);
        route_t r;
        r.full   = full_mode & seg_ok;
        r.bypass = ~r.full;
        return r;
    endfunction

    function automatic logic seg_live(input bdom_state_e s);
        return (s == B_ON_ISO) || (s == B_ON);
    endfunction

endpackage

// File: rtl/pds_pg_sync.sv
module pds_pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[LAST];
endmodule

// File: rtl/pds_b_seq.sv
module pds_b_seq
    import pds_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             pg_sync,
    input  logic [CNT_W-1:0] settle,
    output logic             seg_ok,
    output logic             iso_en
);
    bdom_state_e      st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             stay_up;

    assign stay_up = req & pg_sync;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            B_OFF: begin
                cnt_nx = '0;
                if (stay_up) st_nx = B_WAKE;
            end
            B_WAKE: begin
                if (!stay_up) begin
                    st_nx  = B_OFF;
                    cnt_nx = '0;
                end else if (cnt >= settle) begin
                    st_nx = B_ON_ISO;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            B_ON_ISO: begin
                if (!stay_up) st_nx = B_OFF;
                else          st_nx = B_ON;
            end
            B_ON: begin
                if (!stay_up) st_nx = B_OFF;
            end
            default: st_nx = B_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= B_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // request removal acts at once; state only widens the window
    assign seg_ok = req & seg_live(st);
    assign iso_en = ~req | (st != B_ON);

    // R4: full release only from the isolated-on step
    a_r4_release_after_enable: assert property (@(posedge clk) disable iff (rst)
        (st == B_ON && $past(st) != B_ON) |-> $past(st) == B_ON_ISO);

    // R2: enabling needs the synchronized power-good
    a_r2_enable_needs_pg: assert property (@(posedge clk) disable iff (rst)
        (seg_live(st) && !$past(seg_live(st))) |-> $past(pg_sync));

    // R10: a lost power-good always restarts the sequence
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        (st == B_WAKE && !pg_sync) |=> (st == B_OFF && cnt == '0));
endmodule

// File: rtl/pds_cg_override.sv
module pds_cg_override #(
    parameter int NCG = 4
) (
    input  logic [NCG-1:0] func_en,
    input  logic           scan_en,
    output logic [NCG-1:0] gate_en
);
    generate
        for (genvar i = 0; i < NCG; i++) begin : g_cg
            assign gate_en[i] = func_en[i] | scan_en;
        end
    endgenerate
endmodule

// File: rtl/pds_iso_clamp.sv
module pds_iso_clamp #(
    parameter int NISO = 8
) (
    input  logic            iso_en,
    input  logic            clamp_val,
    input  logic [NISO-1:0] d_in,
    output logic [NISO-1:0] d_out
);
    generate
        for (genvar i = 0; i < NISO; i++) begin : g_iso
            assign d_out[i] = iso_en ? clamp_val : d_in[i];
        end
    endgenerate
endmodule

// File: rtl/pds_seg_ctrl.sv
module pds_seg_ctrl
    import pds_pkg::*;
#(
    parameter int NCG         = 4,
    parameter int NISO        = 8,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             b_pwr_req,
    input  logic             b_pwr_good,
    input  logic             scan_en,
    input  logic             full_mode,
    input  logic [CNT_W-1:0] settle_cycles,
    input  logic             clamp_val,
    input  logic [NCG-1:0]   func_cg_en,
    input  logic [NISO-1:0]  b_func_out,
    input  logic             seg_a_so,
    input  logic             seg_b_so,
    output logic             se_a,
    output logic             se_b,
    output logic [NCG-1:0]   cg_en,
    output logic             iso_en,
    output logic [NISO-1:0]  b_iso_out,
    output logic             bypass_sel,
    output logic             seg_b_si,
    output logic             scan_out
);
    logic   pg_sync;
    logic   seg_ok;
    route_t rt;

    pds_pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (b_pwr_good),
        .q_sync  (pg_sync)
    );

    pds_b_seq #(.CNT_W(CNT_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (b_pwr_req),
        .pg_sync (pg_sync),
        .settle  (settle_cycles),
        .seg_ok  (seg_ok),
        .iso_en  (iso_en)
    );

    pds_cg_override #(.NCG(NCG)) u_cg (
        .func_en (func_cg_en),
        .scan_en (scan_en),
        .gate_en (cg_en)
    );

    pds_iso_clamp #(.NISO(NISO)) u_iso (
        .iso_en    (iso_en),
        .clamp_val (clamp_val),
        .d_in      (b_func_out),
        .d_out     (b_iso_out)
    );

    assign rt         = pick_route(full_mode, seg_ok);
    assign se_a       = scan_en;
    assign se_b       = scan_en & rt.full;
    assign bypass_sel = rt.bypass;
    assign seg_b_si   = rt.full & seg_a_so;
    assign scan_out   = rt.full ? seg_b_so : seg_a_so;

    // R1: segment B never shifts without global enable or in bypass
    a_r1_se_b_gated: assert property (@(posedge clk) disable iff (rst)
        se_b |-> (scan_en && !bypass_sel));

    // R3: no shifting of B while its request is withdrawn
    a_r3_req_drop: assert property (@(posedge clk) disable iff (rst)
        !b_pwr_req |-> (!se_b && iso_en));

    // R5: clamped outputs never unknown and at the clamp level
    a_r5_clamp: assert property (@(posedge clk) disable iff (rst)
        iso_en |-> (b_iso_out == {NISO{clamp_val}}));

    // R6: shift keeps every gate open
    a_r6_gates_open: assert property (@(posedge clk) disable iff (rst)
        scan_en |-> (&cg_en));

    // R8: reset leaves B isolated and skipped
    a_r8_reset: assert property (@(posedge clk)
        $past(rst) |-> (iso_en && bypass_sel && !se_b));
endmodule

// File: tb/tb_pds_seg_ctrl.sv
module tb_pds_seg_ctrl;
    localparam int NCG = 4;
    localparam int NISO = 8;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst;
    logic             b_pwr_req, b_pwr_good, scan_en, full_mode, clamp_val;
    logic [CNT_W-1:0] settle_cycles;
    logic [NCG-1:0]   func_cg_en;
    logic [NISO-1:0]  b_func_out;
    logic             seg_a_so, seg_b_so;
    logic             se_a, se_b, iso_en, bypass_sel, seg_b_si, scan_out;
    logic [NCG-1:0]   cg_en;
    logic [NISO-1:0]  b_iso_out;

    int tests = 0;
    int fails = 0;

    // bench model of the power sequence
    logic p1 = 1'b0, p2 = 1'b0;
    int   run = 0;

    always #10 clk = ~clk;

    pds_seg_ctrl #(.NCG(NCG), .NISO(NISO), .CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .b_pwr_req(b_pwr_req), .b_pwr_good(b_pwr_good),
        .scan_en(scan_en), .full_mode(full_mode), .settle_cycles(settle_cycles),
        .clamp_val(clamp_val), .func_cg_en(func_cg_en), .b_func_out(b_func_out),
        .seg_a_so(seg_a_so), .seg_b_so(seg_b_so), .se_a(se_a), .se_b(se_b),
        .cg_en(cg_en), .iso_en(iso_en), .b_iso_out(b_iso_out),
        .bypass_sel(bypass_sel), .seg_b_si(seg_b_si), .scan_out(scan_out)
    );

    function automatic logic exp_ok();
        return b_pwr_req && (run >= int'(settle_cycles) + 2);
    endfunction

    function automatic logic exp_iso();
        return !b_pwr_req || (run < int'(settle_cycles) + 3);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // model update at a rising edge, from pre-edge values
    task automatic step();
        @(posedge clk);
        if (rst) begin
            run = 0; p1 = 1'b0; p2 = 1'b0;
        end else begin
            if (!b_pwr_req || !p2) run = 0;
            else run++;
            p2 = p1;
            p1 = b_pwr_good;
        end
    endtask

    task automatic check_all();
        logic full;
        full = full_mode && exp_ok();
        chk(se_a, scan_en, "R1 se_a");
        chk(se_b, scan_en && full, "R1 se_b");
        chk(iso_en, exp_iso(), "R4 iso_en");
        chk(b_iso_out, exp_iso() ? {NISO{clamp_val}} : b_func_out, "R5 b_iso_out");
        chk(cg_en, scan_en ? {NCG{1'b1}} : func_cg_en, "R6 cg_en");
        chk(bypass_sel, !full, "R7 bypass_sel");
        chk(seg_b_si, full ? seg_a_so : 1'b0, "R7 seg_b_si");
        chk(scan_out, full ? seg_b_so : seg_a_so, "R7 scan_out");
    endtask

    task automatic rand_data();
        scan_en    = 1'($urandom_range(0, 1));
        func_cg_en = NCG'($urandom);
        b_func_out = NISO'($urandom);
        seg_a_so   = 1'($urandom_range(0, 1));
        seg_b_so   = 1'($urandom_range(0, 1));
    endtask

    // directed ramp: pg rises before edge 0, check edge of enable
    task automatic ramp(input int st, input string tag_en, input string tag_iso);
        @(negedge clk);
        b_pwr_req = 1'b1; b_pwr_good = 1'b0; full_mode = 1'b1; scan_en = 1'b1;
        settle_cycles = CNT_W'(st);
        repeat (4) begin step(); @(negedge clk); end
        b_pwr_good = 1'b1;
        for (int k = 0; k <= st + 6; k++) begin
            step();
            @(negedge clk);
            #2;
            chk(!bypass_sel, k >= st + 3, tag_en);
            chk(iso_en, k < st + 4, tag_iso);
            check_all();
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst = 1'b1; b_pwr_req = 1'b0; b_pwr_good = 1'b0; scan_en = 1'b0;
        full_mode = 1'b0; clamp_val = 1'b1; settle_cycles = '0;
        func_cg_en = '0; b_func_out = 8'hA5; seg_a_so = 1'b0; seg_b_so = 1'b1;
        repeat (3) step();
        @(negedge clk); #2;
        chk(iso_en, 1'b1, "R8 iso after reset");
        chk(bypass_sel, 1'b1, "R8 bypass after reset");
        chk(se_b, 1'b0, "R8 se_b after reset");
        chk(b_iso_out, 8'hFF, "R8 clamp after reset");
        rst = 1'b0;

        // R2 timing with a nonzero settle count
        ramp(5, "R2 enable edge", "R4 iso release edge");
        // R9 zero settle
        b_pwr_good = 1'b0; b_pwr_req = 1'b0;
        repeat (4) begin step(); @(negedge clk); end
        ramp(0, "R9 enable edge", "R4 iso release zero");

        // R3 request withdrawn while shifting: same-cycle effect
        @(negedge clk);
        b_pwr_req = 1'b0; clamp_val = 1'b0; #2;
        chk(iso_en, 1'b1, "R3 iso on req drop");
        chk(se_b, 1'b0, "R3 se_b on req drop");
        chk(b_iso_out, 8'h00, "R5 clamp zero");
        b_pwr_req = 1'b1;
        // R3 power-good loss: disabled after edge 2
        @(negedge clk); b_pwr_good = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step(); @(negedge clk); #2;
            chk(!bypass_sel, k < 2, "R3 pg loss edge");
        end

        // R10 glitch mid-count restarts the settle count
        b_pwr_good = 1'b0; settle_cycles = 8'd6;
        repeat (4) begin step(); @(negedge clk); end
        b_pwr_good = 1'b1;
        repeat (5) begin step(); @(negedge clk); end
        b_pwr_good = 1'b0;
        step(); @(negedge clk);
        b_pwr_good = 1'b1;
        for (int k = 0; k < 16; k++) begin
            step(); @(negedge clk); #2;
            chk(!bypass_sel, exp_ok(), "R10 restart");
            check_all();
        end

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            rand_data();
            if ($urandom_range(0, 39) == 0) b_pwr_req = ~b_pwr_req;
            if (b_pwr_req && !b_pwr_good && $urandom_range(0, 3) == 0) b_pwr_good = 1'b1;
            else if (!b_pwr_req && b_pwr_good && $urandom_range(0, 2) == 0) b_pwr_good = 1'b0;
            else if (b_pwr_req && $urandom_range(0, 59) == 0) b_pwr_good = 1'b0;
            if ($urandom_range(0, 29) == 0) full_mode = ~full_mode;
            if ($urandom_range(0, 19) == 0) clamp_val = ~clamp_val;
            if (run == 0 && $urandom_range(0, 9) == 0) settle_cycles = CNT_W'($urandom_range(0, 6));
            #2;
            check_all();
            step();
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule